// File: doc/BRIEF.md
# Cascadable CAM Match-Priority Slice

This block is one slice of a content-addressable memory built to be stacked in a vertical chain. Each slice holds a small array of words, each with its own valid bit. A compare cycle checks a search key against every valid word at the same time. The slice keeps the resulting hit vector until the next compare.

Each slice takes an active-low match input from the slice above it and produces an active-low match output for the slice below. The slice at the head of the chain has its match input tied high. The match output of the slice at the tail is the system-wide match indication. The multiple-match outputs of all slices are combined wired-AND (active low) into a system multiple-match flag.

For reads and writes at the highest-priority match address, the chain picks a single slice: the first slice with a hit. Within a slice, the lowest-indexed hit wins. The slice asserts a drive enable that, at chip level, controls the tri-state buffers of the shared data and address buses.

A cycle is framed by the active-low chip enable. The command is sampled on the first clock edge that sees the enable low. The command takes effect on the first edge that sees the enable high again.

The sequencer has five states:
- `ST_IDLE` waits for the enable.
- `ST_CMP` is a compare.
- `ST_WR` is an addressed write.
- `ST_HPMW` is a write at the highest-priority match.
- `ST_HPMR` is a read of the highest-priority match.

Its transitions are:
- ST_IDLE to the state named by the command when the enable is low.
- Any command state back to ST_IDLE when the enable is high, which is the commit edge.
- Otherwise, the current state holds.

Top module: `cam_slice`

## Requirements
- R1: `match_out_n` is low exactly when `match_in_n` is low or the stored hit vector has at least one bit set.
- R2: `mult_out_n` is low when `match_in_n` is high and two or more stored hits exist, or when `match_in_n` is low and exactly one stored hit exists; otherwise it is high.
- R3: The stored hit vector, and with it both flags, changes only on the edge that ends a compare cycle (chip enable seen high again). While the enable stays low, the previous result is held.
- R4: `bus_oe` is high only in ST_HPMR, and only with `oe_n` low, `cs_n` low, `match_in_n` high and at least one stored hit. A slice below a matching slice never drives, even with hits of its own.
- R5: While driving, `bus_addr` is the lowest index with a stored hit, and `bus_data` is the word stored there.
- R6: A highest-priority-match write (cmd 2'b10) stores the latched data at the lowest hit index and marks it valid. It does so only if `cs_n` was low at cycle start, `match_in_n` is high at the commit edge and a hit exists.
- R7: Compare (cmd 2'b00) and addressed write (cmd 2'b01) do not depend on `match_in_n`. An addressed write with `cs_n` low at cycle start stores `wr_data` at `addr_in` with valid bit `wr_vld`.
- R8: Command codes are 2'b00 compare, 2'b01 addressed write, 2'b10 write at highest-priority match, and 2'b11 read at highest-priority match. Command, data, address and valid bit are latched on the first edge with `ce_n` low.
- R9: An entry whose valid bit is clear never produces a hit.
- R10: After reset all entries are invalid, no hits are stored, both flags are high and `bus_oe` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Active-low chip enable framing one cycle |
| cs_n | input | 1 | Active-low slice select (writes and bus drive) |
| oe_n | input | 1 | Active-low output enable |
| cmd | input | 2 | Command code |
| wr_data | input | WIDTH | Search key or write data |
| addr_in | input | AW | Entry index for addressed write |
| wr_vld | input | 1 | Valid bit stored by addressed write |
| match_in_n | input | 1 | Active-low match from higher-priority slice |
| match_out_n | output | 1 | Active-low match to lower-priority slice |
| mult_out_n | output | 1 | Active-low multiple-match flag |
| bus_data | output | WIDTH | Highest-priority match word (zero when not driving) |
| bus_addr | output | AW | Highest-priority match index (zero when not driving) |
| bus_oe | output | 1 | Drive enable for the shared buses |

## Verification
The in-line assertions check the following on every cycle:
- A low match input always forces a low match output.
- The multiple-match flag never falls without the match flag.
- The drive enable only appears with output enable, select and a high match input.
- The hit vector stays put while the enable is low.

The lowest-index choice, the word actually read, the single-driver property across a three-slice chain, and whether a write lands in the right slice can only be shown by the bench's scenarios. These scenarios place matching words in different slices and then compare, read back and re-compare.

// File: rtl/cam_slice_pkg.sv
package cam_slice_pkg;

    typedef enum logic [1:0] {
        CMD_CMP  = 2'b00,
        CMD_WR   = 2'b01,
        CMD_HPMW = 2'b10,
        CMD_HPMR = 2'b11
    } cmd_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMP,
        ST_WR,
        ST_HPMW,
        ST_HPMR
    } st_e;

endpackage

// File: rtl/cam_store.sv
module cam_store #(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [AW-1:0]      wr_idx,
    input  logic [WIDTH-1:0]   wr_word,
    input  logic               wr_vld,
    input  logic [WIDTH-1:0]   key,
    input  logic [AW-1:0]      rd_idx,
    output logic [ENTRIES-1:0] hit_now,
    output logic [WIDTH-1:0]   rd_word
);

    logic [WIDTH-1:0]   mem_q [ENTRIES];
    logic [ENTRIES-1:0] valid_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q <= '0;
        end else if (wr_en) begin
            valid_q[wr_idx] <= wr_vld;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_idx] <= wr_word;
        end
    end

    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
        assign hit_now[g] = valid_q[g] && (mem_q[g] == key);
    end

    assign rd_word = mem_q[rd_idx];

endmodule

// File: rtl/cam_prio.sv
module cam_prio #(
    parameter int ENTRIES = 16,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic [ENTRIES-1:0] hits,
    output logic               any_hit,
    output logic               one_hit,
    output logic               many_hit,
    output logic [AW-1:0]      idx
);

    logic [1:0] cnt;

    always_comb begin
        idx = '0;
        cnt = '0;
        for (int i = ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) idx = AW'(i);
        end
        for (int i = 0; i < ENTRIES; i++) begin
            if (hits[i] && cnt != 2'd2) cnt = cnt + 2'd1;
        end
    end

    assign any_hit  = |hits;
    assign one_hit  = (cnt == 2'd1);
    assign many_hit = (cnt == 2'd2);

endmodule

// File: rtl/cam_seq.sv
module cam_seq
    import cam_slice_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               ce_n,
    input  logic               cs_n,
    input  logic [1:0]         cmd,
    input  logic [WIDTH-1:0]   wr_data,
    input  logic [AW-1:0]      addr_in,
    input  logic               wr_vld,
    input  logic               match_in_n,
    input  logic [ENTRIES-1:0] hit_now,
    input  logic               hpm_any,
    input  logic [AW-1:0]      hpm_idx,
    output st_e                state_q,
    output logic [ENTRIES-1:0] hit_q,
    output logic [WIDTH-1:0]   key_q,
    output logic               wr_en,
    output logic [AW-1:0]      wr_idx,
    output logic [WIDTH-1:0]   wr_word,
    output logic               wr_vld_o
);

    st_e           state_d;
    logic [AW-1:0] addr_q;
    logic          vld_q;
    logic          cs_n_q;
    logic          hit_load;

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (!ce_n) begin
                    unique case (cmd_e'(cmd))
                        CMD_CMP:  state_d = ST_CMP;
                        CMD_WR:   state_d = ST_WR;
                        CMD_HPMW: state_d = ST_HPMW;
                        CMD_HPMR: state_d = ST_HPMR;
                        default:  state_d = ST_IDLE;
                    endcase
                end
            end
            ST_CMP, ST_WR, ST_HPMW, ST_HPMR: begin
                if (ce_n) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register and cycle latches
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            hit_q   <= '0;
            key_q   <= '0;
            addr_q  <= '0;
            vld_q   <= 1'b0;
            cs_n_q  <= 1'b1;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && !ce_n) begin
                key_q  <= wr_data;
                addr_q <= addr_in;
                vld_q  <= wr_vld;
                cs_n_q <= cs_n;
            end
            if (hit_load) hit_q <= hit_now;
        end
    end

    // Commit outputs
    always_comb begin
        hit_load = 1'b0;
        wr_en    = 1'b0;
        wr_idx   = addr_q;
        wr_word  = key_q;
        wr_vld_o = vld_q;
        if (ce_n) begin
            unique case (state_q)
                ST_CMP: hit_load = 1'b1;
                ST_WR:  wr_en = !cs_n_q;
                ST_HPMW: begin
                    wr_en    = !cs_n_q && match_in_n && hpm_any;
                    wr_idx   = hpm_idx;
                    wr_vld_o = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // R3
    hold_while_enabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ce_n |=> $stable(hit_q));

endmodule

// File: rtl/cam_slice.sv
module cam_slice
    import cam_slice_pkg::*;
#(
    parameter int ENTRIES = 16,
    parameter int WIDTH   = 32,
    localparam int AW     = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ce_n,
    input  logic             cs_n,
    input  logic             oe_n,
    input  logic [1:0]       cmd,
    input  logic [WIDTH-1:0] wr_data,
    input  logic [AW-1:0]    addr_in,
    input  logic             wr_vld,
    input  logic             match_in_n,
    output logic             match_out_n,
    output logic             mult_out_n,
    output logic [WIDTH-1:0] bus_data,
    output logic [AW-1:0]    bus_addr,
    output logic             bus_oe
);

    st_e                state_q;
    logic [ENTRIES-1:0] hit_q;
    logic [ENTRIES-1:0] hit_now;
    logic [WIDTH-1:0]   key_q;
    logic               wr_en;
    logic [AW-1:0]      wr_idx;
    logic [WIDTH-1:0]   wr_word;
    logic               wr_vld_i;
    logic               any_hit, one_hit, many_hit;
    logic [AW-1:0]      hpm_idx;
    logic [WIDTH-1:0]   rd_word;

    cam_seq #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_seq (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs_n(cs_n), .cmd(cmd),
        .wr_data(wr_data), .addr_in(addr_in), .wr_vld(wr_vld),
        .match_in_n(match_in_n), .hit_now(hit_now), .hpm_any(any_hit),
        .hpm_idx(hpm_idx), .state_q(state_q), .hit_q(hit_q), .key_q(key_q),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_word(wr_word), .wr_vld_o(wr_vld_i)
    );

    cam_store #(.ENTRIES(ENTRIES), .WIDTH(WIDTH)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
        .wr_word(wr_word), .wr_vld(wr_vld_i), .key(key_q), .rd_idx(hpm_idx),
        .hit_now(hit_now), .rd_word(rd_word)
    );

    cam_prio #(.ENTRIES(ENTRIES)) u_prio (
        .hits(hit_q), .any_hit(any_hit), .one_hit(one_hit),
        .many_hit(many_hit), .idx(hpm_idx)
    );

    assign match_out_n = !(!match_in_n || any_hit);
    assign mult_out_n  = !((match_in_n && many_hit) || (!match_in_n && one_hit));
    assign bus_oe      = (state_q == ST_HPMR) && !oe_n && !cs_n && match_in_n && any_hit;
    assign bus_data    = bus_oe ? rd_word : '0;
    assign bus_addr    = bus_oe ? hpm_idx : '0;

    // R1
    chain_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_in_n |-> !match_out_n);

    // R2
    mult_implies_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !mult_out_n |-> !match_out_n);

    // R4
    drive_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bus_oe |-> (match_in_n && !oe_n && !cs_n && !match_out_n));

    // R4
    drive_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !match_in_n |-> !bus_oe);

endmodule

// File: tb/cam_slice_bench.sv
module cam_slice_bench;

    localparam int CLK_PERIOD = 10;
    localparam int NS = 3;

    typedef struct {
        int          req;
        logic        sm;
        logic        mm;
        int          own;
        logic [31:0] data;
        logic [3:0]  addr;
    } exp_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1;
    logic        oe_n = 1'b1;
    logic [1:0]  cmd = 2'b00;
    logic [31:0] wdat = '0;
    logic [3:0]  waddr = '0;
    logic        wvld = 1'b0;
    logic [NS-1:0] csn = '1;

    logic [NS:0]   mi_chain;
    logic [NS-1:0] mm_v;
    logic [NS-1:0] oe_v;
    logic [31:0]   dat_v [NS];
    logic [3:0]    adr_v [NS];

    exp_t exp_q [$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    assign mi_chain[0] = 1'b1;

    for (genvar g = 0; g < NS; g++) begin : g_chain
        cam_slice u_cam_slice (
            .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .cs_n(csn[g]), .oe_n(oe_n),
            .cmd(cmd), .wr_data(wdat), .addr_in(waddr), .wr_vld(wvld),
            .match_in_n(mi_chain[g]), .match_out_n(mi_chain[g+1]),
            .mult_out_n(mm_v[g]), .bus_data(dat_v[g]), .bus_addr(adr_v[g]),
            .bus_oe(oe_v[g])
        );
    end

    // Monitor: pops one expected item per falling edge and compares
    always @(negedge clk) begin
        exp_t e;
        int own;
        logic [31:0] od;
        logic [3:0] oa;
        bit bad;
        if (exp_q.size() > 0) begin
            e = exp_q.pop_front();
            own = 3;
            od = '0;
            oa = '0;
            if ($countones(oe_v) > 1) own = 7;
            else for (int k = 0; k < NS; k++) if (oe_v[k]) own = k;
            if (own < NS) begin
                od = dat_v[own];
                oa = adr_v[own];
            end
            bad = (mi_chain[NS] !== e.sm) || ((&mm_v) !== e.mm) || (own != e.own) ||
                  ((own < NS) && ((od !== e.data) || (oa !== e.addr)));
            n_chk++;
            if (bad) begin
                n_bad++;
                $display("FAIL R%0d: got sm=%b mm=%b owner=%0d data=%h addr=%0d, expected sm=%b mm=%b owner=%0d data=%h addr=%0d",
                         e.req, mi_chain[NS], &mm_v, own, od, oa,
                         e.sm, e.mm, e.own, e.data, e.addr);
            end
        end
    end

    task automatic expect_item(input int req, input logic sm, input logic mm,
                               input int own, input logic [31:0] d, input logic [3:0] a);
        exp_t e;
        e.req = req; e.sm = sm; e.mm = mm; e.own = own; e.data = d; e.addr = a;
        exp_q.push_back(e);
        @(posedge clk);
        #1;
    endtask

    // One framed cycle; optionally checks the held flags mid-cycle
    task automatic cyc(input logic [1:0] c, input logic [31:0] d, input logic [3:0] a,
                       input logic v, input logic [NS-1:0] cs, input bit mid,
                       input logic msm, input logic mmm);
        @(posedge clk); #1;
        ce_n = 1'b0; cmd = c; wdat = d; waddr = a; wvld = v; csn = cs;
        @(posedge clk); #1;
        @(posedge clk); #1;
        if (mid) expect_item(3, msm, mmm, 3, '0, '0); // R3
        ce_n = 1'b1; csn = '1;
        @(posedge clk); #1;
    endtask

    task automatic wr(input int s, input logic [3:0] a, input logic [31:0] d, input logic v);
        cyc(2'b01, d, a, v, ~(NS'(1) << s), 1'b0, 1'b0, 1'b0);
    endtask

    task automatic cmp(input logic [31:0] d);
        cyc(2'b00, d, '0, 1'b0, '1, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic rd(input logic [NS-1:0] cs, input logic oen, input int req,
                      input logic sm, input logic mm, input int own,
                      input logic [31:0] d, input logic [3:0] a);
        @(posedge clk); #1;
        ce_n = 1'b0; cmd = 2'b11; csn = cs; oe_n = oen;
        @(posedge clk); #1;
        expect_item(req, sm, mm, own, d, a);
        ce_n = 1'b1; oe_n = 1'b1; csn = '1;
        @(posedge clk); #1;
    endtask

    localparam logic [31:0] KA = 32'hA5A5_0001;
    localparam logic [31:0] KB = 32'h0BB0_1234;
    localparam logic [31:0] KC = 32'hC0DE_7777;
    localparam logic [31:0] KD = 32'hDDDD_0042;
    localparam logic [31:0] KE = 32'h1234_5678;
    localparam logic [31:0] KF = 32'hF00D_F00D;
    localparam logic [31:0] KG = 32'h6060_0606;

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        expect_item(10, 1'b1, 1'b1, 3, '0, '0); // R10
        rd('0, 1'b0, 10, 1'b1, 1'b1, 3, '0, '0); // R10

        wr(0, 4'd3, KB, 1'b1);
        wr(1, 4'd5, KA, 1'b1);
        wr(1, 4'd9, KA, 1'b1);
        wr(2, 4'd0, KB, 1'b1);
        wr(2, 4'd2, KC, 1'b1);
        wr(2, 4'd4, KD, 1'b1);
        wr(2, 4'd7, KD, 1'b1);
        wr(2, 4'd11, KA, 1'b1);

        // R1 R5: single match in tail slice
        cmp(KC);
        rd('0, 1'b0, 1, 1'b0, 1'b1, 2, KC, 4'd2);
        // R2 R4: slice1 wins, slice2 below it has its own hit
        cmp(KA);
        rd('0, 1'b0, 4, 1'b0, 1'b0, 1, KA, 4'd5);
        // R3: previous flags held while enable low
        cyc(2'b00, KD, '0, 1'b0, '1, 1'b1, 1'b0, 1'b0);
        // R5: lowest index of two hits, R2 many hits with match in high
        rd('0, 1'b0, 5, 1'b0, 1'b0, 2, KD, 4'd4);
        // R2 R4: head slice wins, lower single hit counts as multiple
        cmp(KB);
        rd('0, 1'b0, 4, 1'b0, 1'b0, 0, KB, 4'd3);
        rd('0, 1'b1, 4, 1'b0, 1'b0, 3, '0, '0);      // R4 output enable off
        rd(3'b001, 1'b0, 4, 1'b0, 1'b0, 3, '0, '0);  // R4 owner deselected
        // R1: no match anywhere
        cmp(KE);
        rd('0, 1'b0, 1, 1'b1, 1'b1, 3, '0, '0);
        // R7: addressed write lands in slice2 although its match input is low
        cmp(KA);
        wr(2, 4'd10, KF, 1'b1);
        expect_item(7, 1'b0, 1'b0, 3, '0, '0); // R7 flags unchanged by write
        cmp(KF);
        rd('0, 1'b0, 7, 1'b0, 1'b1, 2, KF, 4'd10);
        // R6: write at highest-priority match only in slice1, entry 5
        cmp(KA);
        cyc(2'b10, KG, '0, 1'b0, '0, 1'b0, 1'b0, 1'b0);
        cmp(KG);
        rd('0, 1'b0, 6, 1'b0, 1'b1, 1, KG, 4'd5);
        cmp(KA);
        rd('0, 1'b0, 6, 1'b0, 1'b0, 1, KA, 4'd9);
        // R9: invalidated entry no longer hits
        wr(2, 4'd2, KC, 1'b0);
        cmp(KC);
        rd('0, 1'b0, 9, 1'b1, 1'b1, 3, '0, '0);
        // R8: command sampled at cycle start, not later changes
        @(posedge clk); #1;
        ce_n = 1'b0; cmd = 2'b00; wdat = KD; csn = '1;
        @(posedge clk); #1;
        cmd = 2'b01; wdat = KE; waddr = 4'd1; csn = '0;
        @(posedge clk); #1;
        ce_n = 1'b1; csn = '1;
        @(posedge clk); #1;
        rd('0, 1'b0, 8, 1'b0, 1'b0, 2, KD, 4'd4);

        repeat (4) @(posedge clk);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got no completion, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule